// File: doc/BRIEF.md
# Opcode Register Command Interpreter

This block sits behind the byte layer of an I2C target. It reads every write transaction as a command. The first byte is an opcode. The second byte is a register address. Any bytes after that are payload. The commands act on a byte-wide register file of 256 entries, which lives outside the block and is reached through a plain address, write-enable, write-data and read-data port.

Four commands are supported:

- **Set bits:** ORs a mask into one register.
- **Clear bits:** removes the mask bits from one register.
- **Block write:** writes successive registers.
- **Block read:** primes a read pointer. A later read phase, after a repeated start, drains successive registers through that pointer.

Wider values are kept low byte first, so a 16-bit quantity takes two neighbouring addresses. Per-channel groups sit at a base plus the channel number times a stride.

The register file must present read data for `rf_addr` in the same cycle (combinational read). The set and clear commands merge the mask with that value and write the result back in the cycle the mask byte arrives.

Top module: `cmd_interp`

## Requirements
- R1: After start, opcode 0x18, address A and mask M, register A is written once with (old value OR M), in the cycle M is valid.
- R2: After start, opcode 0x20, address A and mask M, register A is written once with (old value AND NOT M).
- R3: After start, opcode 0x28 and address A, each further byte is written to A, A+1, A+2 and so on, one write per byte.
- R4: After start, opcode 0x30 and address A, a repeated start and then read requests return the registers at A, A+1 and so on. Each returned byte appears on `tgt_rd_data` in the cycle after its `tgt_rd_req`.
- R5: The register pointer wraps from 0xFF to 0x00, for block writes and for block reads.
- R6: A first byte after start that is not one of 0x18, 0x20, 0x28 or 0x30 causes every further byte of that transaction to be ignored, with no register write.
- R7: A read request without a block-read setup returns 0x00. This applies after reset, after a stop, and after an unknown opcode.
- R8: A stop ends the command. Bytes that arrive after a stop and before the next start cause no write. Bytes that follow the mask of a set or clear command cause no write.
- R9: While reset is held, and right after it, `rf_wr_en` is 0 and `tgt_rd_data` is 0x00.
- R10: A payload byte that is valid in the same cycle as stop is still written. The command is then closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_start | input | 1 | Start or repeated start seen |
| tgt_stop | input | 1 | Stop seen |
| tgt_wr_valid | input | 1 | One written byte is valid |
| tgt_wr_data | input | 8 | Written byte |
| tgt_rd_req | input | 1 | Controller requests one read byte |
| tgt_rd_data | output | 8 | Read byte, valid the cycle after the request |
| rf_addr | output | 8 | Register file address |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_data | output | 8 | Register file write data |
| rf_rd_data | input | 8 | Register file read data for `rf_addr`, combinational |

## Verification
The two events that can share a cycle are a last payload byte and the stop that closes the transaction. The bench raises byte-valid and stop on the same clock edge during a block write. It then checks that the byte lands in the register file, and that a byte sent afterwards without a new start writes nothing. It judges both results by the register-file contents and by a count of write strobes.

// File: rtl/cmdi_pkg.sv
package cmdi_pkg;

    localparam logic [7:0] OPC_SET   = 8'h18;
    localparam logic [7:0] OPC_CLR   = 8'h20;
    localparam logic [7:0] OPC_BLKWR = 8'h28;
    localparam logic [7:0] OPC_BLKRD = 8'h30;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET,
        OP_CLR,
        OP_WR,
        OP_RD
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_MASK,
        PH_DATA,
        PH_SKIP
    } phase_e;

    function automatic op_e decode_opcode(input logic [7:0] b);
        case (b)
            OPC_SET:   return OP_SET;
            OPC_CLR:   return OP_CLR;
            OPC_BLKWR: return OP_WR;
            OPC_BLKRD: return OP_RD;
            default:   return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cmdi_opdecode.sv
module cmdi_opdecode
    import cmdi_pkg::*;
(
    input  logic [7:0] in_byte,
    output op_e        op
);
    always_comb op = decode_opcode(in_byte);
endmodule

// File: rtl/cmdi_bitmerge.sv
module cmdi_bitmerge
    import cmdi_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           mode,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] merged
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_comb begin
            case (mode)
                OP_SET:  merged[i] = cur[i] | mask[i];
                OP_CLR:  merged[i] = cur[i] & ~mask[i];
                default: merged[i] = cur[i];
            endcase
        end
    end
endmodule

// File: rtl/cmdi_readback.sv
module cmdi_readback #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic          armed,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= armed ? src : '0;
        end
    end
endmodule

// File: rtl/cmd_interp.sv
module cmd_interp
    import cmdi_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tgt_start,
    input  logic          tgt_stop,
    input  logic          tgt_wr_valid,
    input  logic [DW-1:0] tgt_wr_data,
    input  logic          tgt_rd_req,
    output logic [DW-1:0] tgt_rd_data,
    output logic [AW-1:0] rf_addr,
    output logic          rf_wr_en,
    output logic [DW-1:0] rf_wr_data,
    input  logic [DW-1:0] rf_rd_data
);
    localparam logic [AW-1:0] PTR_STEP = AW'(1);

    phase_e        ph;
    op_e           op_q;
    op_e           dec_op;
    logic [AW-1:0] ptr;
    logic          armed;
    logic [DW-1:0] merged;

    cmdi_opdecode u_dec (
        .in_byte (tgt_wr_data[7:0]),
        .op      (dec_op)
    );

    cmdi_bitmerge #(.DW(DW)) u_merge (
        .mode   (op_q),
        .cur    (rf_rd_data),
        .mask   (tgt_wr_data),
        .merged (merged)
    );

    cmdi_readback #(.DW(DW)) u_rb (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (tgt_rd_req),
        .armed   (armed),
        .src     (rf_rd_data),
        .rd_data (tgt_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            op_q  <= OP_NONE;
            ptr   <= '0;
            armed <= 1'b0;
        end else begin
            if (tgt_wr_valid) begin
                case (ph)
                    PH_OPC: begin
                        op_q  <= dec_op;
                        armed <= 1'b0;
                        ph    <= (dec_op == OP_NONE) ? PH_SKIP : PH_ADDR;
                    end
                    PH_ADDR: begin
                        ptr <= tgt_wr_data[AW-1:0];
                        case (op_q)
                            OP_SET, OP_CLR: ph <= PH_MASK;
                            OP_WR:          ph <= PH_DATA;
                            OP_RD: begin
                                armed <= 1'b1;
                                ph    <= PH_SKIP;
                            end
                            default:        ph <= PH_SKIP;
                        endcase
                    end
                    PH_MASK: ph  <= PH_SKIP;
                    PH_DATA: ptr <= ptr + PTR_STEP;
                    default: ;
                endcase
            end
            if (tgt_rd_req && armed) begin
                ptr <= ptr + PTR_STEP;
            end
            if (tgt_start) begin
                ph <= PH_OPC;
            end
            if (tgt_stop) begin
                ph    <= PH_IDLE;
                armed <= 1'b0;
            end
        end
    end

    always_comb begin
        rf_addr    = ptr;
        rf_wr_en   = tgt_wr_valid && (ph == PH_MASK || ph == PH_DATA);
        rf_wr_data = (ph == PH_DATA) ? tgt_wr_data : merged;
    end

endmodule

// File: rtl/cmd_interp_chk.sv
module cmd_interp_chk
    import cmdi_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          tgt_wr_valid,
    input logic          tgt_rd_req,
    input logic [DW-1:0] tgt_rd_data,
    input logic [AW-1:0] rf_addr,
    input logic          rf_wr_en,
    input logic [DW-1:0] rf_wr_data,
    input logic [DW-1:0] rf_rd_data,
    input op_e           mode,
    input logic          armed
);
    a_r1_set_keeps_bits: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && mode == OP_SET) |-> ((rf_wr_data & rf_rd_data) == rf_rd_data));

    a_r2_clr_adds_none: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && mode == OP_CLR) |-> ((rf_wr_data & ~rf_rd_data) == '0));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && $past(rf_wr_en)) |-> (rf_addr == AW'($past(rf_addr) + 1'b1)));

    a_r7_unarmed_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(tgt_rd_req) && !$past(armed)) |-> (tgt_rd_data == '0));

    a_r8_write_needs_byte: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> tgt_wr_valid);

    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (tgt_rd_data == '0));
endmodule

bind cmd_interp cmd_interp_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tgt_wr_valid (tgt_wr_valid),
    .tgt_rd_req   (tgt_rd_req),
    .tgt_rd_data  (tgt_rd_data),
    .rf_addr      (rf_addr),
    .rf_wr_en     (rf_wr_en),
    .rf_wr_data   (rf_wr_data),
    .rf_rd_data   (rf_rd_data),
    .mode         (op_q),
    .armed        (armed)
);

// File: tb/cmd_interp_tb_top.sv
`timescale 1ns/1ps
module cmd_interp_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tgt_start = 1'b0;
    logic       tgt_stop = 1'b0;
    logic       tgt_wr_valid = 1'b0;
    logic [7:0] tgt_wr_data = 8'h00;
    logic       tgt_rd_req = 1'b0;
    logic [7:0] tgt_rd_data;
    logic [7:0] rf_addr;
    logic       rf_wr_en;
    logic [7:0] rf_wr_data;
    logic [7:0] rf_rd_data;

    logic [7:0] mem [256];
    int wr_count = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cmd_interp dut_i (
        .clk(clk), .rst(rst), .tgt_start(tgt_start), .tgt_stop(tgt_stop),
        .tgt_wr_valid(tgt_wr_valid), .tgt_wr_data(tgt_wr_data),
        .tgt_rd_req(tgt_rd_req), .tgt_rd_data(tgt_rd_data),
        .rf_addr(rf_addr), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
        .rf_rd_data(rf_rd_data)
    );

    assign rf_rd_data = mem[rf_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (rf_wr_en) begin
            mem[rf_addr] <= rf_wr_data;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); tgt_start = 1'b1;
        @(posedge clk); #1 tgt_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); tgt_stop = 1'b1;
        @(posedge clk); #1 tgt_stop = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b, input logic with_stop);
        @(negedge clk); tgt_wr_valid = 1'b1; tgt_wr_data = b; tgt_stop = with_stop;
        @(posedge clk); #1 tgt_wr_valid = 1'b0; tgt_stop = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] b);
        @(negedge clk); tgt_rd_req = 1'b1;
        @(posedge clk); #1 tgt_rd_req = 1'b0;
        b = tgt_rd_data;
    endtask

    task automatic blk_write2(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1);
        do_start(); do_byte(8'h28, 1'b0); do_byte(a, 1'b0);
        do_byte(d0, 1'b0); do_byte(d1, 1'b0); do_stop();
    endtask

    task automatic t_reset();
        chk("R9 rd_data after reset", tgt_rd_data, 8'h00);
        chk("R9 wr_en after reset", rf_wr_en, 0);
    endtask

    task automatic t_set();
        int c;
        blk_write2(8'h40, 8'h81, 8'h5A);
        c = wr_count;
        do_start(); do_byte(8'h18, 1'b0); do_byte(8'h40, 1'b0); do_byte(8'h06, 1'b0);
        do_byte(8'hFF, 1'b0); do_stop();
        chk("R1 set bits", mem[8'h40], 8'h87);
        chk("R1 single write", wr_count - c, 1);
        chk("R8 byte after mask ignored", mem[8'h41], 8'h5A);
    endtask

    task automatic t_clear();
        blk_write2(8'h50, 8'hFF, 8'h3C);
        do_start(); do_byte(8'h20, 1'b0); do_byte(8'h50, 1'b0); do_byte(8'h0F, 1'b0); do_stop();
        chk("R2 clear bits", mem[8'h50], 8'hF0);
        chk("R2 neighbour kept", mem[8'h51], 8'h3C);
    endtask

    task automatic t_block();
        logic [7:0] r;
        blk_write2(8'hA0, 8'h34, 8'h12);
        chk("R3 low byte", mem[8'hA0], 8'h34);
        chk("R3 high byte", mem[8'hA1], 8'h12);
        do_start(); do_byte(8'h30, 1'b0); do_byte(8'hA0, 1'b0);
        do_start(); do_read(r); chk("R4 read first", r, 8'h34);
        do_read(r); chk("R4 read second", r, 8'h12);
        do_stop();
    endtask

    task automatic t_wrap();
        logic [7:0] r;
        blk_write2(8'hFF, 8'h11, 8'h22);
        chk("R5 write at FF", mem[8'hFF], 8'h11);
        chk("R5 write wraps to 00", mem[8'h00], 8'h22);
        do_start(); do_byte(8'h30, 1'b0); do_byte(8'hFF, 1'b0);
        do_start(); do_read(r); chk("R5 read at FF", r, 8'h11);
        do_read(r); chk("R5 read wraps", r, 8'h22);
        do_stop();
    endtask

    task automatic t_unknown();
        int c;
        logic [7:0] r;
        c = wr_count;
        do_start(); do_byte(8'h55, 1'b0); do_byte(8'h10, 1'b0); do_byte(8'h99, 1'b0);
        do_byte(8'h77, 1'b0);
        do_start(); do_read(r);
        do_stop();
        chk("R6 no write on unknown opcode", wr_count - c, 0);
        chk("R6 register kept", mem[8'h10], 8'h00);
        chk("R7 read after unknown opcode", r, 8'h00);
    endtask

    task automatic t_unarmed();
        logic [7:0] r;
        do_start(); do_read(r); do_stop();
        chk("R7 read with no setup", r, 8'h00);
    endtask

    task automatic t_stop();
        int c;
        do_start(); do_byte(8'h28, 1'b0); do_byte(8'h60, 1'b0); do_byte(8'hAB, 1'b0); do_stop();
        c = wr_count;
        do_byte(8'hCD, 1'b0);
        chk("R8 byte after stop ignored", wr_count - c, 0);
        chk("R8 next register kept", mem[8'h61], 8'h00);
    endtask

    task automatic t_stop_same_cycle();
        int c;
        do_start(); do_byte(8'h28, 1'b0); do_byte(8'h30, 1'b0); do_byte(8'h77, 1'b1);
        chk("R10 byte with stop written", mem[8'h30], 8'h77);
        c = wr_count;
        do_byte(8'h88, 1'b0);
        chk("R10 command closed", wr_count - c, 0);
        chk("R10 next register kept", mem[8'h31], 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_set();
        t_clear();
        t_block();
        t_wrap();
        t_unknown();
        t_unarmed();
        t_stop();
        t_stop_same_cycle();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule